// File: doc/BRIEF.md
# Quad DAC serial load interface

This block is the digital front end of a four-channel digital-to-analog converter. A host sends 24-bit command frames over a three-wire link: an active-low frame strobe, a serial clock and a data line. Each frame carries a two-bit device address, a load-control field, a channel select, a power-down bit and a 16-bit sample. A frame is accepted only when its address matches two strap pins. It writes the sample into that channel's input register and may also update one or all of the DAC registers, depending on its load-control field.

A separate load strobe copies every input register into its DAC register on its rising edge. This lets several channels, or several devices, change their outputs together. An active-low port enable disconnects the link completely while it is high. All link pins are oversampled in the system clock domain. The system clock must run at least four times faster than the serial clock. The block drives the four DAC register values and one power-down flag per channel.

Top module: `quad_dac_serial_if`

## Requirements
- R1: After reset, every input register, every DAC register and every power-down flag reads zero.
- R2: An accepted frame is sent most significant bit first and has this layout: bits 23:22 address, bits 21:20 load control, bits 19:18 channel (00 = A, 01 = B, 10 = C, 11 = D), bit 17 power-down, bit 16 unused, bits 15:0 data. Load control 00 (and the spare value 11) writes only the selected input register and leaves all DAC registers unchanged.
- R3: Load control 01 writes the selected input register and copies the new value into that channel's DAC register only.
- R4: Load control 10 writes the selected input register and then copies all four input registers into their DAC registers.
- R5: A frame whose address field differs from the strap pins changes no register and no flag.
- R6: If the frame strobe returns high before the 24th falling serial clock edge, the partial frame is discarded and no register changes.
- R7: While the port enable is high, the serial clock and data are ignored, and no frame is accepted.
- R8: A rising edge on the load strobe copies every input register into its DAC register in the same cycle.
- R9: Serial clock edges after the 24th edge of a frame are ignored until the frame strobe goes high and then low again.
- R10: An accepted frame sets the selected channel's power-down flag to the frame's power-down bit.
- R11: Data bits are taken on falling edges of the serial clock.
- R12: The DAC value of channel k (A = 0 to D = 3) appears on bits 16k+15 down to 16k of the DAC value output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n_i | input | 1 | Active-low frame strobe |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| din_i | input | 1 | Serial data, most significant bit first |
| en_n_i | input | 1 | Active-low port enable |
| ldac_i | input | 1 | Load strobe; a rising edge updates all DAC registers |
| addr_strap_i | input | 2 | Device address straps |
| dac_val_o | output | 64 | DAC register values, channel A in the low 16 bits |
| pd_o | output | 4 | Per-channel power-down flags, bit k for channel k |

## Verification
The hardest effects to see are the ones that must not happen: an aborted, disabled or wrongly addressed frame that could have left stale data in an input register. Input registers are not visible at the ports. After each such frame, the stimulus therefore pulses the load strobe, which brings every input register out to the DAC outputs, and compares the result with the last value that was legally written. The overlong frame case sends 32 clocks inside one strobe. The extra eight bits differ from the frame's own low bits, so a receiver that kept shifting would show a different sample.

// File: rtl/qdac_pkg.sv
// Shared constants and types for the quad DAC serial load interface.
// Assumes a fixed 24-bit frame, most significant bit first.
package qdac_pkg;

    localparam int FRAME_BITS = 24;
    localparam int DATA_W     = 16;
    localparam int N_CH       = 4;
    localparam int CH_W       = 2;

    // Load-control field of a frame
    typedef enum logic [1:0] {
        LD_INPUT_ONLY = 2'b00,
        LD_UPDATE_ONE = 2'b01,
        LD_UPDATE_ALL = 2'b10,
        LD_SPARE      = 2'b11
    } ld_mode_e;

    // Frame layout, first-sent bit at the top
    typedef struct packed {
        logic [1:0]        addr;
        ld_mode_e          mode;
        logic [CH_W-1:0]   ch;
        logic              pd;
        logic              unused;
        logic [DATA_W-1:0] data;
    } frame_t;

endpackage

// File: rtl/qdac_in_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous single-bit inputs.
// Each bit is synchronized on its own. Assumes the inputs are slow compared
// with clk, so a bundle skew of one cycle does no harm.
module qdac_in_sync #(
    parameter int             W       = 5,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the inputs one stage deeper each clock
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= (s == 0) ? d_i : chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/qdac_edge.sv
// Single-edge detector on a signal that is already synchronized.
// FALLING selects the detected polarity. The output is a pulse one cycle long.
module qdac_edge #(
    parameter bit FALLING = 1'b0,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic edge_o
);

    logic prev_q;

    // Remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    generate
        if (FALLING) begin : g_fall
            assign edge_o = prev_q & ~lvl_i;
        end else begin : g_rise
            assign edge_o = ~prev_q & lvl_i;
        end
    endgenerate

endmodule

// File: rtl/qdac_frame_rx.sv
// Frame receiver: counts falling serial clock edges inside an active frame
// and shifts data in. After the last bit it gives a one-cycle valid pulse
// with the whole word. A strobe release or a port disable drops any partial
// frame. Edges after the last bit are ignored until a new strobe falls.
// Assumes all inputs are synchronized to clk.
module qdac_frame_rx #(
    parameter int FRAME_BITS = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sync_n_i,
    input  logic                  sync_fall_i,
    input  logic                  sclk_fall_i,
    input  logic                  din_i,
    input  logic                  en_off_i,
    output logic                  valid_o,
    output logic [FRAME_BITS-1:0] word_o
);

    localparam int                CNT_W    = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(FRAME_BITS - 1);

    logic                  active_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] shift_q;
    logic [FRAME_BITS-1:0] shift_nxt;

    assign shift_nxt = {shift_q[FRAME_BITS-2:0], din_i};

    // Frame state, bit counter, shifter and completed-word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            shift_q  <= '0;
            valid_o  <= 1'b0;
            word_o   <= '0;
        end else begin
            valid_o <= 1'b0;
            if (en_off_i || sync_n_i) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else if (sync_fall_i) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
            end else if (active_q && sclk_fall_i) begin
                shift_q <= shift_nxt;
                if (cnt_q == LAST_BIT) begin
                    valid_o  <= 1'b1;
                    word_o   <= shift_nxt;
                    active_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/qdac_reg_bank.sv
// Double-buffered channel registers: input registers are written by frames
// and DAC registers are updated by the frame's load-control field or by the
// load strobe. When a frame and the strobe land in the same cycle, the strobe
// copies the input values that already include that frame's write.
module qdac_reg_bank
    import qdac_pkg::*;
#(
    parameter int NCH = N_CH,
    parameter int DW  = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  frame_t            frame_i,
    input  logic [1:0]        strap_i,
    input  logic              load_i,
    output logic [NCH*DW-1:0] in_flat_o,
    output logic [NCH*DW-1:0] dac_flat_o,
    output logic [NCH-1:0]    pd_o
);

    logic          hit;
    logic [NCH-1:0] sel;

    assign hit = valid_i && (frame_i.addr == strap_i);

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_ch
            logic [DW-1:0] in_q, in_nxt, dac_q;
            logic          dac_upd;

            assign sel[k]  = hit && (frame_i.ch == CH_W'(k));
            assign in_nxt  = sel[k] ? frame_i.data : in_q;
            assign dac_upd = load_i
                          || (hit && frame_i.mode == LD_UPDATE_ALL)
                          || (sel[k] && frame_i.mode == LD_UPDATE_ONE);

            // Channel input register, DAC register and power-down flag
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    in_q     <= '0;
                    dac_q    <= '0;
                    pd_o[k]  <= 1'b0;
                end else begin
                    in_q <= in_nxt;
                    if (dac_upd) dac_q   <= in_nxt;
                    if (sel[k])  pd_o[k] <= frame_i.pd;
                end
            end

            assign in_flat_o[k*DW +: DW]  = in_q;
            assign dac_flat_o[k*DW +: DW] = dac_q;
        end
    endgenerate

endmodule

// File: rtl/quad_dac_serial_if.sv
// Top level of the quad DAC serial load interface. It synchronizes the link
// pins, detects the edges it needs, receives frames and updates the channel
// register bank. Assumes clk is at least 4x the serial clock and that the
// address straps are static.
module quad_dac_serial_if
    import qdac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sync_n_i,
    input  logic                   sclk_i,
    input  logic                   din_i,
    input  logic                   en_n_i,
    input  logic                   ldac_i,
    input  logic [1:0]             addr_strap_i,
    output logic [N_CH*DATA_W-1:0] dac_val_o,
    output logic [N_CH-1:0]        pd_o
);

    localparam int PIN_W = 5;
    // Bundle order: {en_n, ldac, din, sclk, sync_n}
    localparam logic [PIN_W-1:0] PIN_IDLE = 5'b10011;

    logic [PIN_W-1:0]      pins_s;
    logic                  sync_n_s, sclk_s, din_s, ldac_s, en_off_s;
    logic                  sync_fall, sclk_fall, ldac_rise;
    logic                  frame_valid;
    logic [FRAME_BITS-1:0] frame_word;
    logic [N_CH*DATA_W-1:0] in_flat;

    qdac_in_sync #(.W(PIN_W), .STAGES(2), .RST_VAL(PIN_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({en_n_i, ldac_i, din_i, sclk_i, sync_n_i}),
        .q_o   (pins_s)
    );

    assign {en_off_s, ldac_s, din_s, sclk_s, sync_n_s} = pins_s;

    qdac_edge #(.FALLING(1'b1), .RST_VAL(1'b1)) u_sync_edge (
        .clk (clk), .rst_n (rst_n), .lvl_i (sync_n_s), .edge_o (sync_fall)
    );

    qdac_edge #(.FALLING(1'b1), .RST_VAL(1'b1)) u_sclk_edge (
        .clk (clk), .rst_n (rst_n), .lvl_i (sclk_s), .edge_o (sclk_fall)
    );

    qdac_edge #(.FALLING(1'b0), .RST_VAL(1'b0)) u_ldac_edge (
        .clk (clk), .rst_n (rst_n), .lvl_i (ldac_s), .edge_o (ldac_rise)
    );

    qdac_frame_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_n_i    (sync_n_s),
        .sync_fall_i (sync_fall),
        .sclk_fall_i (sclk_fall),
        .din_i       (din_s),
        .en_off_i    (en_off_s),
        .valid_o     (frame_valid),
        .word_o      (frame_word)
    );

    qdac_reg_bank #(.NCH(N_CH), .DW(DATA_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (frame_valid),
        .frame_i    (frame_t'(frame_word)),
        .strap_i    (addr_strap_i),
        .load_i     (ldac_rise),
        .in_flat_o  (in_flat),
        .dac_flat_o (dac_val_o),
        .pd_o       (pd_o)
    );

endmodule

// File: rtl/qdac_chk.sv
// Property checker for quad_dac_serial_if. It watches the completed-frame
// pulse, the load edge and the register bank, and is attached by bind.
module qdac_chk #(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_valid,
    input logic [23:0]       frame_word,
    input logic              ldac_rise,
    input logic              en_off,
    input logic [1:0]        strap,
    input logic [NCH*DW-1:0] in_flat,
    input logic [NCH*DW-1:0] dac_flat,
    input logic [NCH-1:0]    pd
);

    logic [1:0]    ch_q;
    logic [DW-1:0] dac_sel;
    logic          hit;

    assign hit = frame_valid && (frame_word[23:22] == strap);

    // Remember the channel of the last frame for next-cycle checks
    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= frame_word[19:18];
    end

    assign dac_sel = dac_flat[int'(ch_q)*DW +: DW];

    // R3
    single_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit && frame_word[21:20] == 2'b01 && !ldac_rise |=> dac_sel == $past(frame_word[15:0]));

    // R5
    addr_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && frame_word[23:22] != strap && !ldac_rise
        |=> $stable(in_flat) && $stable(dac_flat) && $stable(pd));

    // R7
    port_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_off |=> !frame_valid);

    // R8
    load_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ldac_rise && !frame_valid |=> dac_flat == $past(in_flat));

    // R10
    pd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pd[ch_q] == $past(frame_word[17]));

endmodule

bind quad_dac_serial_if qdac_chk #(.NCH(4), .DW(16)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame_word  (frame_word),
    .ldac_rise   (ldac_rise),
    .en_off      (en_off_s),
    .strap       (addr_strap_i),
    .in_flat     (in_flat),
    .dac_flat    (dac_val_o),
    .pd          (pd_o)
);

// File: tb/quad_dac_serial_if_test.sv
module quad_dac_serial_if_test;

    localparam int HALF  = 4;
    localparam logic [1:0] STRAP = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_n = 1'b1, sclk = 1'b1, din = 1'b0, en_n = 1'b0, ldac = 1'b0;
    logic [63:0] dac_val;
    logic [3:0]  pd;

    int total = 0;
    int bad   = 0;

    typedef struct {
        string       req;
        logic [63:0] dac;
        logic [3:0]  pd;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] m_in [4];
    logic [15:0] m_dac[4];
    logic [3:0]  m_pd;

    always #4 clk = ~clk;

    quad_dac_serial_if uut (
        .clk (clk), .rst_n (rst_n), .sync_n_i (sync_n), .sclk_i (sclk),
        .din_i (din), .en_n_i (en_n), .ldac_i (ldac), .addr_strap_i (STRAP),
        .dac_val_o (dac_val), .pd_o (pd)
    );

    function automatic logic [23:0] mk(input logic [1:0] a, input logic [1:0] m,
                                       input logic [1:0] c, input logic p,
                                       input logic [15:0] d);
        return {a, m, c, p, 1'b0, d};
    endfunction

    // Bench model of an accepted 24-bit word (R2, R3, R4, R10)
    function automatic void model_frame(input logic [23:0] w);
        int c;
        if (w[23:22] != STRAP) return;
        c = int'(w[19:18]);
        m_in[c] = w[15:0];
        m_pd[c] = w[17];
        if (w[21:20] == 2'b01) m_dac[c] = w[15:0];
        if (w[21:20] == 2'b10) for (int k = 0; k < 4; k++) m_dac[k] = m_in[k];
    endfunction

    task automatic push(input string req);
        exp_t e;
        e.req = req;
        for (int k = 0; k < 4; k++) e.dac[k*16 +: 16] = m_dac[k];
        e.pd = m_pd;
        sb_q.push_back(e);
        repeat (3) @(negedge clk);
    endtask

    // Drive nbits from the low end of bits, MSB first (R11: falling edges)
    task automatic shift_out(input logic [31:0] bits, input int nbits);
        @(negedge clk); sync_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            din = bits[i];
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
        end
        repeat (HALF) @(negedge clk);
        sync_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic load_pulse();
        @(negedge clk); ldac = 1'b1;
        repeat (HALF) @(negedge clk);
        ldac = 1'b0;
        repeat (10) @(negedge clk);
        for (int k = 0; k < 4; k++) m_dac[k] = m_in[k];
    endtask

    // Monitor: pop each expected item and compare per channel and flags
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                for (int k = 0; k < 4; k++) begin
                    total++;
                    if (dac_val[k*16 +: 16] !== e.dac[k*16 +: 16]) begin
                        bad++;
                        $display("FAIL %s ch%0d dac actual=%h expected=%h",
                                 e.req, k, dac_val[k*16 +: 16], e.dac[k*16 +: 16]);
                    end
                end
                total++;
                if (pd !== e.pd) begin
                    bad++;
                    $display("FAIL %s pd actual=%b expected=%b", e.req, pd, e.pd);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin m_in[k] = '0; m_dac[k] = '0; end
        m_pd = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        push("R1 reset");

        // R2: input-only write, DACs untouched
        shift_out({8'h0, mk(STRAP, 2'b00, 2'd0, 1'b0, 16'h1234)}, 24);
        model_frame(mk(STRAP, 2'b00, 2'd0, 1'b0, 16'h1234));
        push("R2 input only");

        // R8: load strobe copies inputs
        load_pulse();
        push("R8 load strobe");

        // R3 and R10: single-channel update with power-down
        shift_out({8'h0, mk(STRAP, 2'b01, 2'd1, 1'b1, 16'hBEEF)}, 24);
        model_frame(mk(STRAP, 2'b01, 2'd1, 1'b1, 16'hBEEF));
        push("R3 R10 update one");

        // R4 and R12: stage C, then update-all through D
        shift_out({8'h0, mk(STRAP, 2'b00, 2'd2, 1'b0, 16'h5555)}, 24);
        model_frame(mk(STRAP, 2'b00, 2'd2, 1'b0, 16'h5555));
        shift_out({8'h0, mk(STRAP, 2'b10, 2'd3, 1'b0, 16'h0F0F)}, 24);
        model_frame(mk(STRAP, 2'b10, 2'd3, 1'b0, 16'h0F0F));
        push("R4 R12 update all");

        // R5: address mismatch then load strobe
        shift_out({8'h0, mk(2'b01, 2'b01, 2'd0, 1'b1, 16'hFFFF)}, 24);
        push("R5 mismatch");
        load_pulse();
        push("R5 mismatch after load");

        // R6: abort after 12 bits
        shift_out({8'h0, mk(STRAP, 2'b01, 2'd0, 1'b1, 16'hAAAA)} >> 12, 12);
        load_pulse();
        push("R6 aborted frame");

        // R7: port disabled
        en_n = 1'b1;
        shift_out({8'h0, mk(STRAP, 2'b01, 2'd2, 1'b1, 16'h7777)}, 24);
        en_n = 1'b0;
        repeat (4) @(negedge clk);
        load_pulse();
        push("R7 port disabled");

        // R9: 32 clocks in one frame, extra bits ignored
        shift_out({mk(STRAP, 2'b01, 2'd3, 1'b0, 16'h1357), 8'hC3}, 32);
        model_frame(mk(STRAP, 2'b01, 2'd3, 1'b0, 16'h1357));
        push("R9 extra clocks");

        // R2: spare load-control value acts as input only
        shift_out({8'h0, mk(STRAP, 2'b11, 2'd0, 1'b1, 16'h2222)}, 24);
        model_frame(mk(STRAP, 2'b11, 2'd0, 1'b1, 16'h2222));
        push("R2 spare mode");
        load_pulse();
        push("R2 spare mode after load");

        // R10: clear power-down of channel B
        shift_out({8'h0, mk(STRAP, 2'b00, 2'd1, 1'b0, 16'h4444)}, 24);
        model_frame(mk(STRAP, 2'b00, 2'd1, 1'b0, 16'h4444));
        push("R10 pd clear");

        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule